// File: doc/BRIEF.md
# Status and Cause Interrupt Controller

This block keeps the processor-control state that governs interrupts and exception nesting in a small in-order core. It holds two software-visible registers. The Status register holds a three-deep stack of privilege/enable pairs and a per-level interrupt mask. The Cause register holds the live pending bits of the external request lines and the code of the most recent exception. The core pulses one input when it takes an exception and another when it returns from one. The controller pushes or pops the privilege/enable stack to match. It raises a registered interrupt request whenever the current enable is set and at least one pending level is unmasked.

Software reads and writes both registers through a single-cycle port. A register select picks Status or Cause, and read data comes back registered one cycle later. The pending field and the exception code cannot be written by software. Only the request lines and exception entry change them.

Top module: `irq_status_ctl`

## Requirements
- R1: After synchronous reset, Status, Cause, `reg_rdata` and `irq_req` are all zero.
- R2: Status bits [5:0] hold three pairs: current in [1:0], previous in [3:2], old in [5:4]. In each pair the lower bit is the interrupt enable (1 = allowed) and the upper bit is the privilege bit (0 = kernel). An `exc_enter` pulse shifts these six bits left by two and clears the current pair.
- R3: An `exc_return` pulse without `exc_enter` shifts the six stack bits right by two. The old pair [5:4] keeps its value.
- R4: An `exc_enter` pulse loads `exc_code` into Cause bits [3:0].
- R5: `irq_req` is 1 exactly one cycle after a cycle in which Status bit 0 is 1 and some pending bit ANDed with its mask bit is 1. The mask for level i is Status bit 8+i.
- R6: Cause bit 8+i shows request line i as sampled on the previous clock edge.
- R7: A software write to Cause (`reg_sel` = 1) changes neither the code nor the pending field.
- R8: A software write to Status (`reg_sel` = 0) with no exception pulse loads bits [5:0] and [12:8] from `reg_wdata`. All other Status bits read as zero.
- R9: When a Status write coincides with `exc_enter` or `exc_return`, the stack takes the shifted value and the mask takes the written value. When `exc_enter` and `exc_return` coincide, entry wins.
- R10: `reg_rdata` shows, one cycle later, the register chosen by `reg_sel` (0 = Status, 1 = Cause) as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 5 | External interrupt request levels |
| exc_enter | input | 1 | Exception-taken pulse |
| exc_code | input | 4 | Reason code stored on entry |
| exc_return | input | 1 | Return-from-exception pulse |
| reg_wr | input | 1 | Software register write strobe |
| reg_sel | input | 1 | 0 selects Status, 1 selects Cause |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
A software write to Status can land in the same cycle as an exception entry or return. Each of these updates the stack, so the bench drives both pulses on one edge. It then reads Status back and compares the stack field with the shifted previous stack and the mask field with the written value. The bench also drives entry and return together and expects the left shift. It judges these collisions against a bench-side model and checks that the request output follows the merged result.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int PAIR_W   = 2;
  localparam int PAIRS    = 3;
  localparam int STACK_W  = PAIR_W * PAIRS;
  localparam int MASK_LSB = 8;
  localparam int PEND_LSB = 8;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CAUSE  = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_LOAD = 2'd3
  } stk_op_e;
endpackage

// File: rtl/irq_mode_stack.sv
module irq_mode_stack
  import irq_ctl_pkg::*;
#(
  parameter int NPAIRS = PAIRS,
  parameter int PW     = PAIR_W,
  localparam int W     = NPAIRS * PW
) (
  input  logic         clk,
  input  logic         rst,
  input  stk_op_e      op,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] stack_o
);
  logic [NPAIRS-1:0][PW-1:0] cur_q;
  logic [NPAIRS-1:0][PW-1:0] nxt;
  logic [NPAIRS-1:0][PW-1:0] ld;

  assign ld = load_val;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    logic [PW-1:0] from_below;
    logic [PW-1:0] from_above;
    if (p == 0) begin : g_bottom
      assign from_below = '0;
    end else begin : g_mid_lo
      assign from_below = cur_q[p-1];
    end
    if (p == NPAIRS-1) begin : g_top
      assign from_above = cur_q[p];
    end else begin : g_mid_hi
      assign from_above = cur_q[p+1];
    end

    always_comb begin
      unique case (op)
        STK_PUSH: nxt[p] = from_below;
        STK_POP:  nxt[p] = from_above;
        STK_LOAD: nxt[p] = ld[p];
        default:  nxt[p] = cur_q[p];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) cur_q[p] <= '0;
      else     cur_q[p] <= nxt[p];
    end
  end

  assign stack_o = cur_q;
endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int NUM_LVL = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] lines,
  output logic [NUM_LVL-1:0] pend
);
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= lines[i];
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NUM_LVL = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glob_en,
  input  logic [NUM_LVL-1:0] pend,
  input  logic [NUM_LVL-1:0] mask,
  output logic               req
);
  logic [NUM_LVL-1:0] live;
  assign live = pend & mask;

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= glob_en & (|live);
  end
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_LVL = 5,
  parameter int CODE_W  = 4,
  parameter int XLEN    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_lines,
  input  logic               exc_enter,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic               exc_return,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [XLEN-1:0]    reg_wdata,
  output logic [XLEN-1:0]    reg_rdata,
  output logic               irq_req
);
  logic [STACK_W-1:0] stack_q;
  logic [NUM_LVL-1:0] mask_q;
  logic [CODE_W-1:0]  code_q;
  logic [NUM_LVL-1:0] pend_q;
  stk_op_e            op;
  logic               wr_status;
  logic [XLEN-1:0]    status_w;
  logic [XLEN-1:0]    cause_w;

  assign wr_status = reg_wr & (reg_sel_e'(reg_sel) == SEL_STATUS);

  always_comb begin
    if (exc_enter)       op = STK_PUSH;
    else if (exc_return) op = STK_POP;
    else if (wr_status)  op = STK_LOAD;
    else                 op = STK_HOLD;
  end

  irq_mode_stack #(.NPAIRS(PAIRS), .PW(PAIR_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (reg_wdata[STACK_W-1:0]),
    .stack_o  (stack_q)
  );

  irq_pend_capture #(.NUM_LVL(NUM_LVL)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .lines (irq_lines),
    .pend  (pend_q)
  );

  irq_req_gen #(.NUM_LVL(NUM_LVL)) u_req (
    .clk     (clk),
    .rst     (rst),
    .glob_en (stack_q[0]),
    .pend    (pend_q),
    .mask    (mask_q),
    .req     (irq_req)
  );

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (wr_status) mask_q <= reg_wdata[MASK_LSB +: NUM_LVL];
  end

  always_ff @(posedge clk) begin
    if (rst)            code_q <= '0;
    else if (exc_enter) code_q <= exc_code;
  end

  always_comb begin
    status_w = '0;
    status_w[STACK_W-1:0] = stack_q;
    status_w[MASK_LSB +: NUM_LVL] = mask_q;
    cause_w = '0;
    cause_w[CODE_W-1:0] = code_q;
    cause_w[PEND_LSB +: NUM_LVL] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= (reg_sel_e'(reg_sel) == SEL_CAUSE) ? cause_w : status_w;
  end
endmodule

// File: rtl/irq_status_ctl_chk.sv
module irq_status_ctl_chk #(
  parameter int NUM_LVL = 5,
  parameter int CODE_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               exc_enter,
  input logic               exc_return,
  input logic [CODE_W-1:0]  exc_code,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [NUM_LVL-1:0] irq_lines,
  input logic               irq_req,
  input logic [5:0]         stack,
  input logic [NUM_LVL-1:0] mask,
  input logic [CODE_W-1:0]  code,
  input logic [NUM_LVL-1:0] pend
);
  p_entry_shift_r2: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (stack == {$past(stack[3:0]), 2'b00}));

  p_return_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (exc_return && !exc_enter) |=> (stack[5:4] == $past(stack[5:4]) && stack[3:0] == $past(stack[5:2])));

  p_code_load_r4: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (code == $past(exc_code)));

  p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(stack[0]) && (|($past(pend) & $past(mask)))));

  p_pend_track_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pend == $past(irq_lines)));

  p_cause_ro_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && !exc_enter) |=> $stable(code));
endmodule

bind irq_status_ctl irq_status_ctl_chk #(.NUM_LVL(NUM_LVL), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exc_enter  (exc_enter),
  .exc_return (exc_return),
  .exc_code   (exc_code),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .irq_lines  (irq_lines),
  .irq_req    (irq_req),
  .stack      (stack_q),
  .mask       (mask_q),
  .code       (code_q),
  .pend       (pend_q)
);

// File: tb/irq_status_ctl_test.sv
module irq_status_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  irq_lines = '0;
  logic        exc_enter = 1'b0;
  logic [3:0]  exc_code = '0;
  logic        exc_return = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;

  irq_status_ctl uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .exc_enter(exc_enter),
    .exc_code(exc_code), .exc_return(exc_return), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    bit          is_req;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // bench model
  logic [5:0] m_stack = '0;
  logic [4:0] m_mask = '0;
  logic [3:0] m_code = '0;
  logic [4:0] m_pend = '0;

  function automatic logic [31:0] m_status();
    return {19'b0, m_mask, 2'b0, m_stack};
  endfunction
  function automatic logic [31:0] m_cause();
    return {19'b0, m_pend, 4'b0, m_code};
  endfunction
  function automatic logic m_req();
    return m_stack[0] & (|(m_pend & m_mask));
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      for (int i = 0; i < q.size(); ) begin
        if (q[i].due == cyc) begin
          logic [31:0] act;
          act = q[i].is_req ? {31'b0, irq_req} : reg_rdata;
          n_tests++;
          if (act !== q[i].exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", q[i].tag, act, q[i].exp);
          end
          q.delete(i);
        end else begin
          i++;
        end
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_read(bit sel, string tag);
    reg_sel = sel;
    q.push_back('{cyc + 1, 1'b0, sel ? m_cause() : m_status(), tag});
    step();
  endtask

  task automatic expect_req(string tag);
    q.push_back('{cyc + 1, 1'b1, {31'b0, m_req()}, tag});
    step();
  endtask

  task automatic write_status(logic [31:0] d);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = d;
    step();
    reg_wr = 1'b0;
    m_stack = d[5:0];
    m_mask  = d[12:8];
  endtask

  task automatic set_lines(logic [4:0] l);
    irq_lines = l;
    m_pend = l;
    step(2);
  endtask

  task automatic enter(logic [3:0] c);
    exc_enter = 1'b1; exc_code = c;
    step();
    exc_enter = 1'b0;
    m_stack = {m_stack[3:0], 2'b00};
    m_code  = c;
  endtask

  task automatic leave();
    exc_return = 1'b1;
    step();
    exc_return = 1'b0;
    m_stack = {m_stack[5:4], m_stack[5:2]};
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    expect_read(1'b0, "R1 status after reset");
    expect_read(1'b1, "R1 cause after reset");
    expect_req("R1 req after reset");

    // R8 write with junk upper bits, then clean write
    write_status(32'hABCD_E0C1);
    expect_read(1'b0, "R8 status ignores unused bits");
    write_status(32'h0000_0401);
    expect_read(1'b0, "R8/R10 status readback");

    // R5 / R6 request generation
    set_lines(5'b00100);
    expect_req("R5 unmasked pending with enable");
    expect_read(1'b1, "R6 pending bits in cause");
    set_lines(5'b00010);
    expect_req("R5 masked level gives no request");
    set_lines(5'b00100);
    write_status(32'h0000_0400);
    step();
    expect_req("R5 global enable clear blocks request");

    // R2 / R4 exception entry
    write_status(32'h0000_040D);
    step();
    expect_req("R5 request before entry");
    enter(4'd9);
    expect_read(1'b0, "R2 stack pushed on entry");
    expect_read(1'b1, "R4 code loaded on entry");
    expect_req("R2 entry disables interrupts");

    // R3 return
    leave();
    expect_read(1'b0, "R3 stack popped, old pair kept");
    step();
    expect_req("R3 request restored after return");

    // R7 cause read-only
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    step();
    reg_wr = 1'b0;
    expect_read(1'b1, "R7 cause unchanged by write");

    // R9 status write with entry in the same cycle
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_1F05;
    exc_enter = 1'b1; exc_code = 4'd3;
    step();
    reg_wr = 1'b0; exc_enter = 1'b0;
    m_stack = {m_stack[3:0], 2'b00};
    m_mask = 5'h1F;
    m_code = 4'd3;
    expect_read(1'b0, "R9 entry wins stack, write sets mask");
    expect_read(1'b1, "R9 code from colliding entry");

    // R9 entry and return together
    write_status(32'h0000_1F39);
    exc_enter = 1'b1; exc_return = 1'b1; exc_code = 4'd12;
    step();
    exc_enter = 1'b0; exc_return = 1'b0;
    m_stack = {m_stack[3:0], 2'b00};
    m_code = 4'd12;
    expect_read(1'b0, "R9 entry beats return");
    step();
    expect_req("R9 request after collision");

    // R9 return with status write: stack pops
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0200;
    exc_return = 1'b1;
    step();
    reg_wr = 1'b0; exc_return = 1'b0;
    m_stack = {m_stack[5:4], m_stack[5:2]};
    m_mask = 5'b00010;
    expect_read(1'b0, "R9 return beats write on stack");

    // R1 reset mid-run
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    irq_lines = '0;
    m_stack = '0; m_mask = '0; m_code = '0; m_pend = '0;
    step();
    expect_read(1'b0, "R1 status after second reset");
    expect_read(1'b1, "R1 cause after second reset");
    expect_req("R1 req after second reset");

    step(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule